// File: doc/BRIEF.md
# Rotating Nested Interrupt Priority Resolver

This block decides, within the same cycle, whether an interrupt controller should raise its interrupt line and which request line wins. It takes the captured request vector, the mask vector and the in-service vector from the surrounding controller. Candidates are the requests that are not masked. The candidates are ranked against a rotation offset held inside the block. An interrupt is raised only when the best candidate strictly outranks the best in-service line. The block also reports the rank of that best in-service line.

Two mode inputs change which in-service bits take part in the comparison. The first makes in-service bits of masked lines invisible. The second applies only when the instance is built as the master: it makes the cascade input's in-service bit invisible, so a second request from the same downstream controller can nest. A rotate strobe moves the offset so that the line just named becomes the lowest priority.

All outputs are combinational functions of the inputs and the offset register. They form a level status rather than a data stream, so the block has no valid/ready handshake and applies no back-pressure. A rotate strobe is accepted on every clock edge where it is high, and it takes effect from the next cycle.

Top module: `prio_nest_resolver`

## Requirements
- R1: After reset the rotation offset is 0, so line 0 has the highest priority and line 7 the lowest.
- R2: Rank of line L is (L - offset) mod 8, with rank 0 highest. The winner is the candidate of lowest rank, and `irq_line_o` equals (rank + offset) mod 8.
- R3: A request whose mask bit is 1 is never a candidate. A bit in `mask_i` set to 1 masks the line with that index.
- R4: With no candidate, `irq_o` is 0 and `irq_line_o` is 0.
- R5: `irq_o` is 1 only when the winning rank is strictly lower than the rank of the best counted in-service line. A candidate whose rank equals that in-service rank does not raise it.
- R6: While `spec_mask_i` is 1, in-service bits of masked lines are left out of the comparison and out of `insvc_rank_o`.
- R7: While `nest_mode_i` is 1 on an instance built with MASTER=1, in-service bit 2 (the cascade line) is left out of the comparison and out of `insvc_rank_o`. On an instance built with MASTER=0 the input has no effect.
- R8: A clock edge with `rot_valid_i` high sets the offset to (`rot_line_i` + 1) mod 8, which makes that line the lowest priority from the next cycle. While the strobe is low, the offset holds.
- R9: `insvc_rank_o` gives the rank of the best counted in-service line, or 8 when none is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Captured request vector |
| mask_i | input | 8 | Mask vector, 1 masks the line |
| insvc_i | input | 8 | In-service vector |
| spec_mask_i | input | 1 | Hide in-service bits of masked lines |
| nest_mode_i | input | 1 | Hide cascade in-service bit (master only) |
| rot_valid_i | input | 1 | Rotate strobe |
| rot_line_i | input | 3 | Line that becomes lowest priority |
| irq_o | output | 1 | Interrupt should be raised |
| irq_line_o | output | 3 | Winning line index |
| insvc_rank_o | output | 4 | Rank of best counted in-service line, 8 if none |

## Verification
The requests are tried with a single line, with several competing lines and with every line active. Each pattern is applied at offset 0, after a rotation to the middle of the range and after a wrap back to 0. This shows whether the ranking really follows the offset or only the line number. The in-service patterns cover a line above the candidate, the same line and a line below it. These tell a strict comparison apart from a non-strict one. The special-mask and nesting inputs are each toggled over the same vectors, on a master instance and on a non-master instance. The result must change only where the mode applies.

// File: rtl/prio_pkg.sv
package prio_pkg;
  parameter int unsigned PRIO_LINES   = 8;
  parameter int unsigned CASCADE_LINE = 2;
endpackage

// File: rtl/prio_rotate.sv
// Rotates a vector right so that element amt_i lands at position 0.
module prio_rotate #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] amt_i,
  output logic [N-1:0]  vec_o
);
  logic [2*N-1:0] dbl;
  always_comb begin
    dbl   = {vec_i, vec_i} >> amt_i;
    vec_o = dbl[N-1:0];
  end
endmodule

// File: rtl/prio_first_set.sv
// Index of the lowest set bit, or N when the vector is empty.
module prio_first_set #(
  parameter int unsigned N  = 8,
  parameter int unsigned RW = 4
) (
  input  logic [N-1:0]  vec_i,
  output logic [RW-1:0] rank_o
);
  localparam logic [RW-1:0] NONE = RW'(N);
  always_comb begin
    rank_o = NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) rank_o = RW'(i);
    end
  end
endmodule

// File: rtl/prio_offset_reg.sv
// Holds the rotation offset; a load makes the named line the lowest priority.
module prio_offset_reg #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] line_i,
  output logic [LW-1:0] off_o
);
  localparam logic [LW-1:0] LAST = LW'(N - 1);
  logic [LW-1:0] next_off;

  always_comb next_off = (line_i == LAST) ? '0 : line_i + LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_o <= '0;
    else if (load_i) off_o <= next_off;
  end
endmodule

// File: rtl/prio_nest_resolver.sv
module prio_nest_resolver #(
  parameter int unsigned N         = prio_pkg::PRIO_LINES,
  parameter bit          MASTER    = 1'b1,
  parameter int unsigned CASC_LINE = prio_pkg::CASCADE_LINE,
  localparam int unsigned LW       = $clog2(N),
  localparam int unsigned RW       = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  insvc_i,
  input  logic          spec_mask_i,
  input  logic          nest_mode_i,
  input  logic          rot_valid_i,
  input  logic [LW-1:0] rot_line_i,
  output logic          irq_o,
  output logic [LW-1:0] irq_line_o,
  output logic [RW-1:0] insvc_rank_o
);
  localparam logic [LW:0] NWIDE = (LW + 1)'(N);

  logic [LW-1:0] off_q;
  logic [N-1:0]  cand, cand_rot;
  logic [N-1:0]  insvc_seen, insvc_rot;
  logic [N-1:0]  insvc_sm;
  logic [RW-1:0] cand_rank, top_rank;
  logic [LW:0]   line_sum;

  prio_offset_reg #(.N(N), .LW(LW)) u_off (
    .clk(clk), .rst_n(rst_n), .load_i(rot_valid_i),
    .line_i(rot_line_i), .off_o(off_q)
  );

  always_comb begin
    cand     = req_i & ~mask_i;
    insvc_sm = spec_mask_i ? (insvc_i & ~mask_i) : insvc_i;
  end

  // Cascade exclusion only exists on the master build.
  generate
    if (MASTER) begin : g_master
      always_comb begin
        insvc_seen = insvc_sm;
        if (nest_mode_i) insvc_seen[CASC_LINE] = 1'b0;
      end
    end else begin : g_slave
      always_comb insvc_seen = insvc_sm;
    end
  endgenerate

  prio_rotate #(.N(N), .LW(LW)) u_rot_req (
    .vec_i(cand), .amt_i(off_q), .vec_o(cand_rot)
  );
  prio_rotate #(.N(N), .LW(LW)) u_rot_isr (
    .vec_i(insvc_seen), .amt_i(off_q), .vec_o(insvc_rot)
  );
  prio_first_set #(.N(N), .RW(RW)) u_enc_req (
    .vec_i(cand_rot), .rank_o(cand_rank)
  );
  prio_first_set #(.N(N), .RW(RW)) u_enc_isr (
    .vec_i(insvc_rot), .rank_o(top_rank)
  );

  // Map the rank back to a line index: (rank + offset) mod N.
  always_comb begin
    line_sum     = {1'b0, cand_rank[LW-1:0]} + {1'b0, off_q};
    irq_o        = (cand_rank < top_rank);
    insvc_rank_o = top_rank;
    if (!irq_o)                irq_line_o = '0;
    else if (line_sum >= NWIDE) irq_line_o = LW'(line_sum - NWIDE);
    else                       irq_line_o = line_sum[LW-1:0];
  end
endmodule

// File: rtl/prio_nest_resolver_chk.sv
module prio_nest_resolver_chk #(
  parameter int unsigned N         = 8,
  parameter bit          MASTER    = 1'b1,
  parameter int unsigned CASC_LINE = 2,
  localparam int unsigned LW       = $clog2(N),
  localparam int unsigned RW       = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  mask_i,
  input logic [N-1:0]  insvc_i,
  input logic          spec_mask_i,
  input logic          nest_mode_i,
  input logic          rot_valid_i,
  input logic          irq_o,
  input logic [LW-1:0] irq_line_o,
  input logic [RW-1:0] insvc_rank_o,
  input logic [LW-1:0] off_q
);
  localparam logic [RW-1:0] NONE = RW'(N);
  localparam logic [LW-1:0] CL   = LW'(CASC_LINE);

  // R3: a winner is always an unmasked request
  p_winner_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_i[irq_line_o] && !mask_i[irq_line_o]));

  // R4: no candidate, no interrupt, line reads zero
  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & ~mask_i) == '0) |-> (!irq_o && irq_line_o == '0));

  p_idle_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_line_o == '0));

  // R5: nothing outranks an in-service level of rank 0
  p_top_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_rank_o == '0) |-> !irq_o);

  // R5: with no mode hiding bits, the winner is not itself in service
  p_winner_not_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !spec_mask_i && !(nest_mode_i && MASTER && irq_line_o == CL))
      |-> !insvc_i[irq_line_o]);

  // R8: offset only moves on a rotate strobe
  p_offset_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_valid_i |=> $stable(off_q));

  // R9: rank stays in range and reads the sentinel exactly when nothing is in service
  p_rank_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_rank_o <= NONE) && ((insvc_i == '0) -> (insvc_rank_o == NONE)));
endmodule

bind prio_nest_resolver prio_nest_resolver_chk #(
  .N(N), .MASTER(MASTER), .CASC_LINE(CASC_LINE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
  .insvc_i(insvc_i), .spec_mask_i(spec_mask_i), .nest_mode_i(nest_mode_i),
  .rot_valid_i(rot_valid_i), .irq_o(irq_o), .irq_line_o(irq_line_o),
  .insvc_rank_o(insvc_rank_o), .off_q(off_q)
);

// File: tb/prio_nest_resolver_tb_top.sv
module prio_nest_resolver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, insvc = '0;
  logic       spec = 1'b0, nest = 1'b0, rot_v = 1'b0;
  logic [2:0] rot_l = '0;
  logic       irq_m, irq_s;
  logic [2:0] line_m, line_s;
  logic [3:0] rank_m, rank_s;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_nest_resolver #(.MASTER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(insvc),
    .spec_mask_i(spec), .nest_mode_i(nest), .rot_valid_i(rot_v),
    .rot_line_i(rot_l), .irq_o(irq_m), .irq_line_o(line_m), .insvc_rank_o(rank_m)
  );

  prio_nest_resolver #(.MASTER(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(insvc),
    .spec_mask_i(spec), .nest_mode_i(nest), .rot_valid_i(rot_v),
    .rot_line_i(rot_l), .irq_o(irq_s), .irq_line_o(line_s), .insvc_rank_o(rank_s)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                       input logic sm, input logic nm);
    req = r; mask = m; insvc = s; spec = sm; nest = nm;
    #2;
  endtask

  task automatic expect_m(input string tag, input int v, input int l, input int rk);
    check(tag, "irq", int'(irq_m), v);
    check(tag, "line", int'(line_m), l);
    check(tag, "insvc_rank", int'(rank_m), rk);
  endtask

  task automatic rotate(input logic [2:0] l);
    @(negedge clk);
    rot_l = l; rot_v = 1'b1;
    @(negedge clk);
    rot_v = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    apply(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R4", 0, 0, 8);
    expect_m("R9", 0, 0, 8);
    apply(8'hFF, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R1", 1, 0, 8);
  endtask

  task automatic t_priority;
    apply(8'hA0, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R2", 1, 5, 8);
    apply(8'h80, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R2", 1, 7, 8);
  endtask

  task automatic t_mask;
    apply(8'h24, 8'h04, 8'h00, 1'b0, 1'b0);
    expect_m("R3", 1, 5, 8);
    apply(8'h24, 8'h24, 8'h00, 1'b0, 1'b0);
    expect_m("R4", 0, 0, 8);
  endtask

  task automatic t_nesting;
    apply(8'h08, 8'h00, 8'h10, 1'b0, 1'b0);
    expect_m("R5", 1, 3, 4);
    apply(8'h10, 8'h00, 8'h10, 1'b0, 1'b0);
    expect_m("R5", 0, 0, 4);
    apply(8'h20, 8'h00, 8'h10, 1'b0, 1'b0);
    expect_m("R5", 0, 0, 4);
  endtask

  task automatic t_special_mask;
    apply(8'h40, 8'h02, 8'h02, 1'b0, 1'b0);
    expect_m("R6", 0, 0, 1);
    apply(8'h40, 8'h02, 8'h02, 1'b1, 1'b0);
    expect_m("R6", 1, 6, 8);
  endtask

  task automatic t_cascade;
    apply(8'h08, 8'h00, 8'h04, 1'b0, 1'b0);
    expect_m("R7", 0, 0, 2);
    apply(8'h08, 8'h00, 8'h04, 1'b0, 1'b1);
    expect_m("R7", 1, 3, 8);
    check("R7", "slave irq", int'(irq_s), 0);
    check("R7", "slave rank", int'(rank_s), 2);
    apply(8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_rotate;
    rotate(3'd4);
    apply(8'hFF, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R8", 1, 5, 8);
    apply(8'h30, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R8", 1, 5, 8);
    apply(8'h11, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R2", 1, 0, 8);
    apply(8'h40, 8'h00, 8'h01, 1'b0, 1'b0);
    expect_m("R9", 1, 6, 3);
    apply(8'h10, 8'h00, 8'h01, 1'b0, 1'b0);
    expect_m("R5", 0, 0, 3);
    // strobe low: rot_line_i changes across edges without effect
    rot_l = 3'd1;
    @(negedge clk); @(negedge clk); #1;
    apply(8'hFF, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R8", 1, 5, 8);
    rotate(3'd7);
    apply(8'h81, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_m("R8", 1, 0, 8);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_mask();
    t_nesting();
    t_special_mask();
    t_cascade();
    t_rotate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule